// File: doc/BRIEF.md
# SHA-1 Four-Round Compression Unit

This block advances the SHA-1 working state by four compression rounds per request. The caller hands it a 128-bit word holding the working variables A, B, C and D, and a second 128-bit word holding four message words. The top lane of the message word already includes the fifth variable E. A 2-bit phase selector picks the round logic function and its additive constant. The unit works through the four rounds one per clock and returns the new A, B, C and D in the same packed layout.

The fifth variable is never part of the interface. A second, single-cycle operation rebuilds it for the next group of rounds. It rotates the A lane of one operand left by 30 bits and adds it to the top lane of the other operand. The three lower lanes of the second operand pass through unchanged. One 512-bit block takes twenty round operations, stepping the selector through its four phases, with a next-E operation between consecutive round operations. Message expansion, padding and the final addition into the chaining value stay with the caller.

A small controller has three states. ST_IDLE waits for a request. ST_ROUND executes one round per clock. ST_FINISH presents the result with a done pulse. The transitions are:
- ST_IDLE to ST_ROUND on a round request.
- ST_IDLE to ST_FINISH on a next-E request.
- ST_ROUND to itself until the fourth round.
- ST_ROUND to ST_FINISH after the fourth round.
- ST_FINISH to ST_IDLE unconditionally.

Top module: `sha1_quad_round_unit`

## Requirements
- R1: While reset is applied and after it is released, busy and done are low and result is all zeros until the first request completes.
- R2: Operand layout: src_a holds A in bits [127:96], B in [95:64], C in [63:32] and D in [31:0]. src_b holds W0+E in [127:96], then W1, W2 and W3 in descending lanes. The round result uses the same layout as src_a, holding A4, B4, C4 and D4.
- R3: Each round computes A' = f(B,C,D) + ROL5(A) + W + E + K, B' = A, C' = ROL30(B), D' = C and E' = D. All additions wrap modulo 2^32. E is zero in the first round because it is folded into lane 0. Rounds two to four use message lanes 1 to 3 in order.
- R4: Selector 0 uses f = (B&C)|(~B&D) with K = 0x5A827999.
- R5: Selector 1 uses f = B^C^D with K = 0x6ED9EBA1. Selector 3 uses the same f with K = 0xCA62C1D6.
- R6: Selector 2 uses f = majority(B,C,D) with K = 0x8F1BBCDC.
- R7: A round request is accepted at a rising edge while idle. Busy is then high for exactly four cycles, followed by a one-cycle done pulse. Result holds its value from that done pulse until the next accepted request.
- R8: A next-E request while idle produces result = {ROL30(src_a[127:96]) + src_b[127:96], src_b[95:0]}. Done pulses in the next cycle and busy stays low.
- R9: If both request strobes are high in the same idle cycle, the round operation is performed and the next-E request is dropped.
- R10: Requests of either kind that arrive while busy or done is high are ignored. They change neither the result nor the timing of the operation in flight.
- R11: Chaining twenty round operations and the next-E operations over the padded block for "abc", then adding the initial chaining value, yields the digest a9993e36 4706816a ba3e2571 7850c26c 9cd0d89d.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| rnd_valid | input | 1 | Request four compression rounds |
| nexte_valid | input | 1 | Request the next-E operation |
| phase_sel | input | 2 | Round function and constant selector |
| src_a | input | 128 | Packed A, B, C, D |
| src_b | input | 128 | Packed message lanes (top lane carries E) |
| busy | output | 1 | High while rounds are executing |
| done | output | 1 | One-cycle pulse when result is valid |
| result | output | 128 | Packed result of the last operation |

## Verification
A round request sampled at one rising edge gives four cycles of busy after that edge. Done and the round result appear after the fifth rising edge. A next-E result and its done pulse appear after the first rising edge following the request. The bench drives inputs at falling edges and advances one falling edge at a time, counting edges from the request. It checks busy in each of the four expected cycles and checks done and the result only in the cycle they are due. In the following cycle it confirms that done has dropped and the result is held.

// File: rtl/sha1q_pkg.sv
package sha1q_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ROUND  = 2'd1,
        ST_FINISH = 2'd2
    } sha1q_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] a;
        logic [WORD_W-1:0] b;
        logic [WORD_W-1:0] c;
        logic [WORD_W-1:0] d;
        logic [WORD_W-1:0] e;
    } sha1q_vars_t;

    function automatic logic [WORD_W-1:0] rol5(input logic [WORD_W-1:0] x);
        return {x[WORD_W-6:0], x[WORD_W-1:WORD_W-5]};
    endfunction

    function automatic logic [WORD_W-1:0] rol30(input logic [WORD_W-1:0] x);
        return {x[1:0], x[WORD_W-1:2]};
    endfunction

    function automatic logic [WORD_W-1:0] phase_const(input logic [1:0] sel);
        logic [WORD_W-1:0] k;
        unique case (sel)
            2'd0:    k = 32'h5A827999;
            2'd1:    k = 32'h6ED9EBA1;
            2'd2:    k = 32'h8F1BBCDC;
            default: k = 32'hCA62C1D6;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/sha1q_round.sv
module sha1q_round
    import sha1q_pkg::*;
(
    input  sha1q_vars_t       cur,
    input  logic [WORD_W-1:0] w,
    input  logic [1:0]        sel,
    output sha1q_vars_t       nxt
);

    logic [WORD_W-1:0] fval;

    // Round logic function chosen by phase selector (R4, R5, R6)
    always_comb begin
        unique case (sel)
            2'd0:    fval = (cur.b & cur.c) | (~cur.b & cur.d);
            2'd2:    fval = (cur.b & cur.c) | (cur.b & cur.d) | (cur.c & cur.d);
            default: fval = cur.b ^ cur.c ^ cur.d;
        endcase
    end

    // One compression step, modulo 2^32 (R3)
    always_comb begin
        nxt.a = fval + rol5(cur.a) + w + cur.e + phase_const(sel);
        nxt.b = cur.a;
        nxt.c = rol30(cur.b);
        nxt.d = cur.c;
        nxt.e = cur.d;
    end

endmodule

// File: rtl/sha1q_nexte.sv
module sha1q_nexte
    import sha1q_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [WORD_W*LANES-1:0] old_state,
    input  logic [WORD_W*LANES-1:0] msg,
    output logic [WORD_W*LANES-1:0] packed_out
);

    localparam int OPW = WORD_W * LANES;

    logic [WORD_W-1:0] top_sum;

    // Rebuild the folded E and add it to the first message lane (R8)
    assign top_sum    = rol30(old_state[OPW-1 -: WORD_W]) + msg[OPW-1 -: WORD_W];
    assign packed_out = {top_sum, msg[OPW-WORD_W-1:0]};

endmodule

// File: rtl/sha1q_ctrl.sv
module sha1q_ctrl
    import sha1q_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rnd_req,
    input  logic                     nexte_req,
    output logic                     load_rounds,
    output logic                     load_nexte,
    output logic                     step,
    output logic [$clog2(LANES)-1:0] cnt,
    output logic                     busy,
    output logic                     done
);

    localparam int CNT_W = $clog2(LANES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LANES - 1);

    sha1q_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rnd_req)        state_d = ST_ROUND;   // R9: rounds win
                else if (nexte_req) state_d = ST_FINISH;
            end
            ST_ROUND: begin
                if (cnt_q == LAST)  state_d = ST_FINISH;
            end
            ST_FINISH:              state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // State register and round counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_ROUND) cnt_q <= cnt_q + 1'b1;
            else                     cnt_q <= '0;
        end
    end

    // Outputs
    always_comb begin
        load_rounds = 1'b0;
        load_nexte  = 1'b0;
        step        = 1'b0;
        busy        = 1'b0;
        done        = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load_rounds = rnd_req;
                load_nexte  = nexte_req & ~rnd_req;
            end
            ST_ROUND: begin
                step = 1'b1;
                busy = 1'b1;
            end
            ST_FINISH: done = 1'b1;
            default: ;
        endcase
    end

    assign cnt = cnt_q;

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    assert_busy_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && rnd_req) |=> busy);
    assert_nexte_fast_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && nexte_req && !rnd_req) |=> (done && !busy));
    assert_ignore_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

endmodule

// File: rtl/sha1_quad_round_unit.sv
module sha1_quad_round_unit
    import sha1q_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rnd_valid,
    input  logic                     nexte_valid,
    input  logic [1:0]               phase_sel,
    input  logic [WORD_W*LANES-1:0]  src_a,
    input  logic [WORD_W*LANES-1:0]  src_b,
    output logic                     busy,
    output logic                     done,
    output logic [WORD_W*LANES-1:0]  result
);

    localparam int OPW   = WORD_W * LANES;
    localparam int CNT_W = $clog2(LANES);

    logic              load_rounds, load_nexte, step;
    logic [CNT_W-1:0]  cnt;
    sha1q_vars_t       vars_q, vars_rnd;
    logic [OPW-1:0]    msg_q;
    logic [1:0]        sel_q;
    logic [WORD_W-1:0] lane [LANES];
    logic [OPW-1:0]    nexte_val;

    sha1q_ctrl #(.LANES(LANES)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .rnd_req     (rnd_valid),
        .nexte_req   (nexte_valid),
        .load_rounds (load_rounds),
        .load_nexte  (load_nexte),
        .step        (step),
        .cnt         (cnt),
        .busy        (busy),
        .done        (done)
    );

    // Split the message operand into lanes, lane 0 at the top (R2)
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane[i] = msg_q[OPW-1-WORD_W*i -: WORD_W];
    end

    sha1q_round u_round (
        .cur (vars_q),
        .w   (lane[cnt]),
        .sel (sel_q),
        .nxt (vars_rnd)
    );

    sha1q_nexte #(.LANES(LANES)) u_nexte (
        .old_state  (src_a),
        .msg        (src_b),
        .packed_out (nexte_val)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vars_q <= '0;
            msg_q  <= '0;
            sel_q  <= '0;
        end else if (load_rounds) begin
            vars_q <= {src_a, {WORD_W{1'b0}}};   // E folded into lane 0 (R3)
            msg_q  <= src_b;
            sel_q  <= phase_sel;
        end else if (load_nexte) begin
            vars_q <= {nexte_val, vars_q.e};
        end else if (step) begin
            vars_q <= vars_rnd;
        end
    end

    assign result = {vars_q.a, vars_q.b, vars_q.c, vars_q.d};

    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load_rounds && !load_nexte) |=> $stable(result));
    assert_sel_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(sel_q));
    assert_msg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(msg_q));

endmodule

// File: tb/sha1_quad_round_unit_test.sv
module sha1_quad_round_unit_test;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rnd_valid = 1'b0;
    logic         nexte_valid = 1'b0;
    logic [1:0]   phase_sel = 2'd0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic         busy, done;
    logic [127:0] result;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sha1_quad_round_unit uut (
        .clk(clk), .rst_n(rst_n), .rnd_valid(rnd_valid), .nexte_valid(nexte_valid),
        .phase_sel(phase_sel), .src_a(src_a), .src_b(src_b),
        .busy(busy), .done(done), .result(result)
    );

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    // Arithmetic model of four rounds from R3..R6
    function automatic logic [127:0] model_rounds(input logic [127:0] s1, input logic [127:0] s2, input logic [1:0] sel);
        logic [31:0] a, b, c, d, e, f, k, t;
        a = s1[127:96]; b = s1[95:64]; c = s1[63:32]; d = s1[31:0]; e = 32'd0;
        case (sel)
            2'd0: k = 32'h5A827999;
            2'd1: k = 32'h6ED9EBA1;
            2'd2: k = 32'h8F1BBCDC;
            default: k = 32'hCA62C1D6;
        endcase
        for (int r = 0; r < 4; r++) begin
            if (sel == 2'd0)      f = (b & c) | (~b & d);
            else if (sel == 2'd2) f = (b & c) | (b & d) | (c & d);
            else                  f = b ^ c ^ d;
            t = f + rl(a, 5) + s2[127-32*r -: 32] + e + k;
            e = d; d = c; c = rl(b, 30); b = a; a = t;
        end
        return {a, b, c, d};
    endfunction

    function automatic logic [31:0] mix(input int i);
        logic [31:0] v;
        v = 32'(i) * 32'h9E3779B9;
        return v ^ (v >> 15) ^ (32'(i) << 7);
    endfunction

    // Round op with timing checks; junk=1 injects requests while busy/done (R10)
    task automatic do_rounds(input logic [127:0] s1, input logic [127:0] s2, input logic [1:0] sel,
                             input bit junk, input bit both, output logic [127:0] res);
        bit tim_ok;
        @(negedge clk);
        src_a = s1; src_b = s2; phase_sel = sel; rnd_valid = 1'b1; nexte_valid = both;
        tim_ok = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (!(busy && !done)) tim_ok = 1'b0;
            if (junk) begin
                src_a = ~s1; src_b = ~s2; phase_sel = sel + 2'd1;
                rnd_valid = k[0]; nexte_valid = ~k[0];
            end else begin
                rnd_valid = 1'b0; nexte_valid = 1'b0;
            end
        end
        @(negedge clk);
        if (!(done && !busy)) tim_ok = 1'b0;
        res = result;
        if (junk) begin
            rnd_valid = 1'b1; nexte_valid = 1'b1; src_a = '1; src_b = '1;
        end else begin
            rnd_valid = 1'b0; nexte_valid = 1'b0;
        end
        check(tim_ok, "R7 busy four cycles then done", {127'd0, tim_ok}, 128'd1);
        @(negedge clk);
        rnd_valid = 1'b0; nexte_valid = 1'b0;
        check(!done && !busy && result == res, "R7/R10 done one cycle and result held", result, res);
    endtask

    task automatic do_nexte(input logic [127:0] s1, input logic [127:0] s2, output logic [127:0] res);
        @(negedge clk);
        src_a = s1; src_b = s2; nexte_valid = 1'b1; rnd_valid = 1'b0;
        @(negedge clk);
        nexte_valid = 1'b0;
        check(done && !busy, "R8 next-E done after one edge, busy low", {126'd0, busy, done}, 128'd1);
        res = result;
        @(negedge clk);
        check(!done && result == res, "R8 next-E result held", result, res);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [127:0] res, exp, s1, s2, nres, prev, abcd;
        logic [31:0]  w [80];
        logic [31:0]  h [5];
        logic [31:0]  e80;
        string tag;

        repeat (3) @(negedge clk);
        check(!busy && !done && result == '0, "R1 during reset", result, '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy && !done && result == '0, "R1 after reset", result, '0);

        // Sweep each selector over varied operands (R2, R3, R4, R5, R6)
        for (int sel = 0; sel < 4; sel++) begin
            for (int v = 0; v < 8; v++) begin
                if (v == 0)      begin s1 = '0; s2 = '0; end
                else if (v == 1) begin s1 = '1; s2 = '1; end
                else begin
                    s1 = {mix(v*11+sel), mix(v*13+1), mix(v*17+2), mix(v*19+3)};
                    s2 = {mix(v*23+4), mix(v*29+sel), mix(v*31+6), mix(v*37+7)};
                end
                do_rounds(s1, s2, 2'(sel), 1'b0, 1'b0, res);
                exp = model_rounds(s1, s2, 2'(sel));
                case (sel)
                    0: tag = "R4 R3 R2 selector 0 rounds";
                    1: tag = "R5 R3 R2 selector 1 rounds";
                    2: tag = "R6 R3 R2 selector 2 rounds";
                    default: tag = "R5 R3 R2 selector 3 rounds";
                endcase
                check(res == exp, tag, res, exp);
            end
        end

        // Next-E sweep including wraparound (R8)
        for (int v = 0; v < 6; v++) begin
            s1 = (v == 0) ? '1 : {mix(v+40), mix(v+41), mix(v+42), mix(v+43)};
            s2 = (v == 0) ? '1 : {mix(v+50), mix(v+51), mix(v+52), mix(v+53)};
            do_nexte(s1, s2, res);
            exp = {rl(s1[127:96], 30) + s2[127:96], s2[95:0]};
            check(res == exp, "R8 next-E value", res, exp);
        end

        // Simultaneous strobes: rounds win (R9)
        s1 = {mix(90), mix(91), mix(92), mix(93)};
        s2 = {mix(94), mix(95), mix(96), mix(97)};
        do_rounds(s1, s2, 2'd2, 1'b0, 1'b1, res);
        exp = model_rounds(s1, s2, 2'd2);
        check(res == exp, "R9 both strobes give round result", res, exp);

        // Requests while busy and done are ignored (R10)
        s1 = {mix(100), mix(101), mix(102), mix(103)};
        s2 = {mix(104), mix(105), mix(106), mix(107)};
        do_rounds(s1, s2, 2'd1, 1'b1, 1'b0, res);
        exp = model_rounds(s1, s2, 2'd1);
        check(res == exp, "R10 junk requests ignored", res, exp);
        repeat (5) @(negedge clk);
        check(result == exp && !busy && !done, "R7 result held while idle", result, exp);

        // Full block for "abc" (R11)
        for (int i = 0; i < 16; i++) w[i] = 32'd0;
        w[0] = 32'h61626380; w[15] = 32'h00000018;
        for (int i = 16; i < 80; i++) w[i] = rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
        h[0] = 32'h67452301; h[1] = 32'hEFCDAB89; h[2] = 32'h98BADCFE;
        h[3] = 32'h10325476; h[4] = 32'hC3D2E1F0;
        abcd = {h[0], h[1], h[2], h[3]};
        do_rounds(abcd, {w[0] + h[4], w[1], w[2], w[3]}, 2'd0, 1'b0, 1'b0, res);
        prev = abcd; abcd = res;
        for (int g = 1; g < 20; g++) begin
            do_nexte(prev, {w[4*g], w[4*g+1], w[4*g+2], w[4*g+3]}, nres);
            do_rounds(abcd, nres, 2'(g / 5), 1'b0, 1'b0, res);
            prev = abcd; abcd = res;
        end
        do_nexte(prev, '0, nres);
        e80 = nres[127:96];
        check(h[0] + abcd[127:96] == 32'ha9993e36, "R11 digest word 0", {96'd0, h[0] + abcd[127:96]}, {96'd0, 32'ha9993e36});
        check(h[1] + abcd[95:64]  == 32'h4706816a, "R11 digest word 1", {96'd0, h[1] + abcd[95:64]},  {96'd0, 32'h4706816a});
        check(h[2] + abcd[63:32]  == 32'hba3e2571, "R11 digest word 2", {96'd0, h[2] + abcd[63:32]},  {96'd0, 32'hba3e2571});
        check(h[3] + abcd[31:0]   == 32'h7850c26c, "R11 digest word 3", {96'd0, h[3] + abcd[31:0]},   {96'd0, 32'h7850c26c});
        check(h[4] + e80          == 32'h9cd0d89d, "R11 digest word 4", {96'd0, h[4] + e80},          {96'd0, 32'h9cd0d89d});

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule